// File: doc/BRIEF.md
# Asynchronous Serial Port with Fractional Stop Length

This block is a full-duplex asynchronous serial transmitter and receiver. A host writes bytes into a transmit FIFO and reads received bytes from a receive FIFO, using one-cycle push and pop strobes. The character format is held in a small register file that is written through a simple address/data port. That format covers the data length (5 to 8 bits), the parity mode and the length of the transmitted stop period. The stop period is set in sixteenths of a bit time, from 1/16 up to two full bits. Changes take effect on the next character, so no reset is needed.

Bit timing comes from a 16-bit divisor of the system clock. The divisor produces an oversampling tick at sixteen times the bit rate. The receiver confirms a start bit at mid-bit and samples each later bit at its centre. It records parity, framing and overrun errors in sticky flags. These flags, together with "receive data available" and "transmitter drained", form five interrupt sources, and each source can be masked on its own. Active-low request-to-send and clear-to-send pins give hardware flow control.

Top module: `uart_fracstop`

## Requirements
- R1: Every bit lasts 16 oversampling ticks. A tick occurs once every D clocks, where D is the divisor register (address 0), and a divisor of 0 behaves as 1.
- R2: The line idles high. A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then a high stop period. Loopback of the transmitter into the receiver recovers each byte masked to the data length. Format register (address 1) bits [1:0] give the length: code n selects n+5 bits.
- R3: Format bits [3:2] select parity: 1 = even (the data bits plus the parity bit hold an even number of ones), 2 = odd, 0 or 3 = no parity bit.
- R4: The transmitted stop period lasts (S+1) ticks, where S is format bits [8:4]. The next start bit follows it within two clocks when data is waiting.
- R5: The receiver accepts a start bit only if the line is still low 8 ticks after the first low sample. A shorter low pulse produces no character and no error.
- R6: When the first stop sample is low, the receiver sets framing flag err_flags[1] and still stores the character. Only the first stop bit is checked.
- R7: When the received parity disagrees with the selected mode, the receiver sets parity flag err_flags[0] and still stores the character.
- R8: A character that completes while the receive FIFO is full, with no pop in that cycle, is discarded and sets overrun flag err_flags[2]. Characters already in the FIFO are kept in order.
- R9: rts_n is low while the receive FIFO holds fewer than RX_DEPTH-1 entries, and high otherwise.
- R10: With format bit 9 set (flow control on) and cts_n high, no new character starts. A character already being sent completes.
- R11: Error flags stay set until a write to address 3 with a one in the matching bit [2:0]. A flag that is set and cleared in the same cycle stays set.
- R12: irq is the OR of the sources ANDed with the mask register (address 2, bits [4:0]). Bit 0 is receive FIFO non-empty, bit 1 is transmitter idle with an empty FIFO, and bits 2, 3 and 4 are the parity, framing and overrun flags.
- R13: After reset, txd=1, rts_n=0, rx_empty=1, tx_full=0, err_flags=0 and irq=0. The defaults are divisor 1, 8 bits, no parity, S=15, flow control off and mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| tx_push | input | 1 | Push tx_data into the transmit FIFO |
| tx_data | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_data | output | 8 | Head of the receive FIFO (show-ahead) |
| rx_empty | output | 1 | Receive FIFO empty |
| err_flags | output | 3 | Sticky flags {overrun, framing, parity} |
| irq | output | 1 | Masked interrupt request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
Two pairs of events can fall on the same clock. The host can push into the transmit FIFO in the cycle the transmitter pulls its next byte. The host can also pop the receive FIFO in the cycle the receiver delivers a character. The bench provokes both with loopback streams: random gaps between pushes, and a reader that pops on a random half of the cycles. Every byte must arrive once, in order and masked to the data length. The overrun case, where the FIFO is full and there is no pop, is provoked directly and judged by the surviving FIFO contents and the overrun flag.

// File: rtl/uart_fs_pkg.sv
package uart_fs_pkg;

    localparam int OVS = 16;

    localparam logic [1:0] ADR_DIV  = 2'd0;
    localparam logic [1:0] ADR_FMT  = 2'd1;
    localparam logic [1:0] ADR_MASK = 2'd2;
    localparam logic [1:0] ADR_CLR  = 2'd3;

    localparam int SRC_RXAV  = 0;
    localparam int SRC_TXMT  = 1;
    localparam int SRC_PAR   = 2;
    localparam int SRC_FRM   = 3;
    localparam int SRC_OVR   = 4;
    localparam int NUM_SRC   = 5;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE3 = 2'd3
    } par_mode_e;

    // layout matches the format register, bit 9 down to bit 0
    typedef struct packed {
        logic       cts_en;
        logic [4:0] stop_len;
        par_mode_e  par;
        logic [1:0] len_code;
    } frame_cfg_t;

    localparam frame_cfg_t FMT_RESET = '{cts_en: 1'b0, stop_len: 5'd15,
                                         par: PAR_NONE, len_code: 2'd3};

    typedef enum logic [2:0] {
        LN_IDLE, LN_START, LN_DATA, LN_PAR, LN_STOP
    } line_st_e;

    function automatic logic [3:0] nbits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [7:0] len_mask(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction

    function automatic logic par_used(input par_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    function automatic logic par_calc(input logic [7:0] d, input logic [1:0] code,
                                      input par_mode_e m);
        logic p;
        p = ^(d & len_mask(code));
        return (m == PAR_ODD) ? ~p : p;
    endfunction

    // receiver shifts in from the top: the character sits in the upper bits
    function automatic logic [7:0] rx_align(input logic [7:0] sh, input logic [1:0] code);
        return sh >> (2'd3 - code);
    endfunction

endpackage

// File: rtl/uart_fs_baud.sv
module uart_fs_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = (divisor == '0) ? '0 : divisor - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= limit) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_fs_fifo.sv
module uart_fs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty,
    output logic [AW:0]  count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == DEPTH[AW:0]);
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_fs_tx.sv
module uart_fs_tx
    import uart_fs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] len_code,
    input  par_mode_e  par,
    input  logic [4:0] stop_len,
    input  logic       cts_en,
    input  logic       cts_n,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_data,
    output logic       fifo_pop,
    output logic       txd,
    output logic       busy
);
    line_st_e   st;
    logic [4:0] tcnt;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       parb;
    logic [1:0] cur_len;
    par_mode_e  cur_par;
    logic [4:0] cur_stop;
    logic       last_bit;

    assign fifo_pop = (st == LN_IDLE) && !fifo_empty && !(cts_en && cts_n);
    assign busy     = (st != LN_IDLE);
    assign last_bit = ({1'b0, bitn} == nbits(cur_len) - 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= LN_IDLE;
            txd      <= 1'b1;
            tcnt     <= '0;
            bitn     <= '0;
            shreg    <= '0;
            parb     <= 1'b0;
            cur_len  <= 2'd3;
            cur_par  <= PAR_NONE;
            cur_stop <= 5'd15;
        end else begin
            case (st)
                LN_IDLE: if (fifo_pop) begin
                    st       <= LN_START;
                    txd      <= 1'b0;
                    tcnt     <= '0;
                    shreg    <= fifo_data;
                    parb     <= par_calc(fifo_data, len_code, par);
                    cur_len  <= len_code;
                    cur_par  <= par;
                    cur_stop <= stop_len;
                end
                LN_START: if (tick) begin
                    if (tcnt == 5'd15) begin
                        st    <= LN_DATA;
                        tcnt  <= '0;
                        bitn  <= '0;
                        txd   <= shreg[0];
                        shreg <= shreg >> 1;
                    end else tcnt <= tcnt + 1'b1;
                end
                LN_DATA: if (tick) begin
                    if (tcnt == 5'd15) begin
                        tcnt <= '0;
                        if (last_bit) begin
                            st  <= par_used(cur_par) ? LN_PAR : LN_STOP;
                            txd <= par_used(cur_par) ? parb : 1'b1;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            txd   <= shreg[0];
                            shreg <= shreg >> 1;
                        end
                    end else tcnt <= tcnt + 1'b1;
                end
                LN_PAR: if (tick) begin
                    if (tcnt == 5'd15) begin
                        st   <= LN_STOP;
                        tcnt <= '0;
                        txd  <= 1'b1;
                    end else tcnt <= tcnt + 1'b1;
                end
                LN_STOP: if (tick) begin
                    if (tcnt == cur_stop) begin
                        st   <= LN_IDLE;
                        tcnt <= '0;
                    end else tcnt <= tcnt + 1'b1;
                end
                default: begin
                    st  <= LN_IDLE;
                    txd <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_fs_rx.sv
module uart_fs_rx
    import uart_fs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxs,
    input  logic [1:0] len_code,
    input  par_mode_e  par,
    output logic       done,
    output logic [7:0] data,
    output logic       par_err,
    output logic       frm_err
);
    line_st_e   st;
    logic [3:0] tcnt;
    logic [2:0] bitn;
    logic [7:0] shreg;
    logic       par_smp;
    logic [1:0] cur_len;
    par_mode_e  cur_par;
    logic [7:0] aligned;

    assign aligned = rx_align(shreg, cur_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LN_IDLE;
            tcnt    <= '0;
            bitn    <= '0;
            shreg   <= '0;
            par_smp <= 1'b0;
            cur_len <= 2'd3;
            cur_par <= PAR_NONE;
            done    <= 1'b0;
            data    <= '0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                LN_IDLE: if (tick && !rxs) begin
                    st      <= LN_START;
                    tcnt    <= '0;
                    cur_len <= len_code;
                    cur_par <= par;
                end
                LN_START: if (tick) begin
                    if (tcnt == 4'd7) begin
                        tcnt <= '0;
                        bitn <= '0;
                        st   <= rxs ? LN_IDLE : LN_DATA;
                    end else tcnt <= tcnt + 1'b1;
                end
                LN_DATA: if (tick) begin
                    if (tcnt == 4'd15) begin
                        tcnt  <= '0;
                        shreg <= {rxs, shreg[7:1]};
                        if ({1'b0, bitn} == nbits(cur_len) - 4'd1)
                            st <= par_used(cur_par) ? LN_PAR : LN_STOP;
                        else
                            bitn <= bitn + 1'b1;
                    end else tcnt <= tcnt + 1'b1;
                end
                LN_PAR: if (tick) begin
                    if (tcnt == 4'd15) begin
                        tcnt    <= '0;
                        par_smp <= rxs;
                        st      <= LN_STOP;
                    end else tcnt <= tcnt + 1'b1;
                end
                LN_STOP: if (tick) begin
                    if (tcnt == 4'd15) begin
                        tcnt    <= '0;
                        st      <= LN_IDLE;
                        done    <= 1'b1;
                        data    <= aligned;
                        par_err <= par_used(cur_par) &&
                                   (par_smp != par_calc(aligned, cur_len, cur_par));
                        frm_err <= !rxs;
                    end else tcnt <= tcnt + 1'b1;
                end
                default: st <= LN_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_fracstop.sv
module uart_fracstop
    import uart_fs_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    localparam int RX_CW   = $clog2(RX_DEPTH) + 1,
    localparam int TX_CW   = $clog2(TX_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    input  logic        tx_push,
    input  logic [7:0]  tx_data,
    output logic        tx_full,
    input  logic        rx_pop,
    output logic [7:0]  rx_data,
    output logic        rx_empty,
    output logic [2:0]  err_flags,
    output logic        irq,
    output logic        txd,
    input  logic        rxd,
    input  logic        cts_n,
    output logic        rts_n
);
    logic [DIV_W-1:0]   divisor;
    frame_cfg_t         fmt_q;
    logic [NUM_SRC-1:0] irq_mask;
    logic [NUM_SRC-1:0] irq_src;
    logic [2:0]         err_set, err_clr;

    logic        tick;
    logic [1:0]  rx_sync;
    logic        tx_empty, tx_pop, tx_busy;
    logic [7:0]  tx_head;
    logic [TX_CW-1:0] tx_count;
    logic        rx_done, rx_perr, rx_ferr, rx_full;
    logic [7:0]  rx_word;
    logic [RX_CW-1:0] rx_count;

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            divisor  <= DIV_W'(1);
            fmt_q    <= FMT_RESET;
            irq_mask <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                ADR_DIV:  divisor  <= cfg_wdata[DIV_W-1:0];
                ADR_FMT:  fmt_q    <= frame_cfg_t'(cfg_wdata[9:0]);
                ADR_MASK: irq_mask <= cfg_wdata[NUM_SRC-1:0];
                default:  ;
            endcase
        end
    end

    assign err_clr = (cfg_wr && cfg_addr == ADR_CLR) ? cfg_wdata[2:0] : 3'b000;
    assign err_set = {rx_done && rx_full && !rx_pop,
                      rx_done && rx_ferr,
                      rx_done && rx_perr};

    always_ff @(posedge clk) begin
        if (rst) err_flags <= '0;
        else     err_flags <= (err_flags & ~err_clr) | err_set;
    end

    always_ff @(posedge clk) begin
        if (rst) rx_sync <= 2'b11;
        else     rx_sync <= {rx_sync[0], rxd};
    end

    uart_fs_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
    );

    uart_fs_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_data), .pop(tx_pop),
        .rdata(tx_head), .full(tx_full), .empty(tx_empty), .count(tx_count)
    );

    uart_fs_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick),
        .len_code(fmt_q.len_code), .par(fmt_q.par), .stop_len(fmt_q.stop_len),
        .cts_en(fmt_q.cts_en), .cts_n(cts_n),
        .fifo_empty(tx_empty), .fifo_data(tx_head), .fifo_pop(tx_pop),
        .txd(txd), .busy(tx_busy)
    );

    uart_fs_rx u_rx (
        .clk(clk), .rst(rst), .tick(tick), .rxs(rx_sync[1]),
        .len_code(fmt_q.len_code), .par(fmt_q.par),
        .done(rx_done), .data(rx_word), .par_err(rx_perr), .frm_err(rx_ferr)
    );

    uart_fs_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_done), .wdata(rx_word), .pop(rx_pop),
        .rdata(rx_data), .full(rx_full), .empty(rx_empty), .count(rx_count)
    );

    assign rts_n = (rx_count >= RX_CW'(RX_DEPTH - 1));

    always_comb begin
        irq_src           = '0;
        irq_src[SRC_RXAV] = !rx_empty;
        irq_src[SRC_TXMT] = tx_empty && !tx_busy;
        irq_src[SRC_PAR]  = err_flags[0];
        irq_src[SRC_FRM]  = err_flags[1];
        irq_src[SRC_OVR]  = err_flags[2];
    end

    assign irq = |(irq_src & irq_mask);

    logic unused_ok;
    assign unused_ok = ^tx_count;
endmodule

// File: rtl/uart_fracstop_chk.sv
module uart_fracstop_chk #(
    parameter int RX_DEPTH = 8,
    localparam int RX_CW   = $clog2(RX_DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic [1:0]       cfg_addr,
    input logic [15:0]      cfg_wdata,
    input logic             txd,
    input logic             rts_n,
    input logic             irq,
    input logic             cts_n,
    input logic             cts_en,
    input logic [2:0]       err_flags,
    input logic [4:0]       irq_mask,
    input logic [RX_CW-1:0] rx_count,
    input logic             rx_done,
    input logic             rx_full,
    input logic             rx_pop,
    input logic             tx_busy
);
    logic [2:0] wclr;
    assign wclr = (cfg_wr && cfg_addr == 2'd3) ? cfg_wdata[2:0] : 3'b000;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);                                                  // R2

    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_full && !rx_pop) |=> err_flags[2]);                  // R8

    AST_RTS_NEAR_FULL: assert property (@(posedge clk) disable iff (rst)
        (rx_count >= RX_CW'(RX_DEPTH - 1)) |-> rts_n);                      // R9

    AST_RTS_ROOM: assert property (@(posedge clk) disable iff (rst)
        (rx_count < RX_CW'(RX_DEPTH - 1)) |-> !rts_n);                      // R9

    AST_CTS_NO_START: assert property (@(posedge clk) disable iff (rst)
        (cts_en && cts_n && !tx_busy) |=> !tx_busy);                        // R10

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((err_flags & $past(err_flags & ~wclr)) == $past(err_flags & ~wclr))); // R11

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (irq_mask == 5'd0) |-> !irq);                                       // R12
endmodule

bind uart_fracstop uart_fracstop_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .txd(txd), .rts_n(rts_n), .irq(irq),
    .cts_n(cts_n), .cts_en(fmt_q.cts_en), .err_flags(err_flags),
    .irq_mask(irq_mask), .rx_count(rx_count), .rx_done(rx_done),
    .rx_full(rx_full), .rx_pop(rx_pop), .tx_busy(tx_busy)
);

// File: tb/uart_fracstop_test.sv
`timescale 1ns/1ps
module uart_fracstop_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_data = 8'd0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic        rx_empty;
    logic [2:0]  err_flags;
    logic        irq;
    logic        txd;
    logic        rxd;
    logic        cts_n = 1'b0;
    logic        rts_n;
    logic        loop_en = 1'b0;
    logic        drv_rxd = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    assign rxd = loop_en ? txd : drv_rxd;

    always #4 clk = ~clk;

    uart_fracstop uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_push(tx_push), .tx_data(tx_data),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
        .rx_empty(rx_empty), .err_flags(err_flags), .irq(irq), .txd(txd),
        .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n)
    );

    function automatic int ticks_of(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic logic [7:0] exp_mask(input logic [7:0] d, input int code);
        return d & (8'hFF >> (3 - code));
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input int code, input int pm);
        logic p;
        p = ^exp_mask(d, code);
        return (pm == 2) ? ~p : p;
    endfunction

    function automatic logic [15:0] fmt_word(input int len, input int pm,
                                             input int stop, input bit cts);
        return {6'd0, cts, 5'(stop), 2'(pm), 2'(len)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        while (tx_full) @(negedge clk);
        tx_push = 1'b1; tx_data = d;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk);
        d = rx_data;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drive one frame on the receive line, bit-exact, then one idle bit
    task automatic drive_frame(input logic [7:0] d, input int len, input int pm,
                               input bit flip_par, input bit stop_val, input int dv);
        int bc;
        bc = 16 * ticks_of(dv);
        @(negedge clk);
        drv_rxd = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < len + 5; i++) begin
            drv_rxd = d[i];
            repeat (bc) @(negedge clk);
        end
        if (pm == 1 || pm == 2) begin
            drv_rxd = exp_par(d, len, pm) ^ flip_par;
            repeat (bc) @(negedge clk);
        end
        drv_rxd = stop_val;
        repeat (bc) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (bc) @(negedge clk);
    endtask

    task automatic wait_txd(input logic v);
        @(negedge clk);
        while (txd !== v) @(negedge clk);
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (txd === 1'b1) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic stop_case(input int s, input int dv);
        int gap;
        wr(2'd0, 16'(dv));
        wr(2'd1, fmt_word(3, 0, s, 1'b0));
        push(8'h00);
        push(8'h00);
        wait_txd(1'b0);
        wait_txd(1'b1);
        count_high(gap);
        // R4: stop period of (S+1) ticks, next start within two clocks
        check_range("R4 stop length", gap, (s + 1) * ticks_of(dv), (s + 1) * ticks_of(dv) + 2);
        idle(16 * ticks_of(dv) * 12);
    endtask

    task automatic bit_time_case(input int dv);
        int hi;
        wr(2'd0, 16'(dv));
        wr(2'd1, fmt_word(3, 0, 15, 1'b0));
        push(8'h01);
        wait_txd(1'b0);
        wait_txd(1'b1);
        count_high(hi);
        // R1 bit period, R2 LSB first: the only high data bit is bit 0
        check("R1 bit period", 32'(hi), 32'(16 * ticks_of(dv)));
        idle(16 * ticks_of(dv) * 11);
        check("R2 idle high after frame", 32'(txd), 32'd1);
    endtask

    task automatic loop_case(input int len, input int pm, input int stop, input int dv, input int n);
        logic [7:0] sent[$];
        logic [7:0] got[$];
        int waitc;
        wr(2'd0, 16'(dv));
        wr(2'd1, fmt_word(len, pm, stop, 1'b0));
        loop_en = 1'b1;
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    logic [7:0] b;
                    b = 8'($urandom);
                    idle(int'($urandom % 40));
                    @(negedge clk);
                    while (tx_full) @(negedge clk);
                    tx_push = 1'b1; tx_data = b;
                    sent.push_back(b);
                    @(negedge clk);
                    tx_push = 1'b0;
                end
            end
            begin
                waitc = 0;
                while (got.size() < n && waitc < n * 16 * ticks_of(dv) * 16 + 2000) begin
                    @(negedge clk);
                    waitc++;
                    if (!rx_empty && ($urandom % 2 == 1)) begin
                        got.push_back(rx_data);
                        rx_pop = 1'b1;
                    end else rx_pop = 1'b0;
                end
                @(negedge clk);
                rx_pop = 1'b0;
            end
        join
        check("R2 loopback count", 32'(got.size()), 32'(n));
        for (int i = 0; i < n && i < got.size(); i++)
            check((pm == 0 || pm == 3) ? "R2 loopback data" : "R3 loopback data parity",
                  32'(got[i]), 32'(exp_mask(sent[i], len)));
        check("R7 no parity error on clean stream", 32'(err_flags), 32'd0);
        loop_en = 1'b0;
    endtask

    initial begin
        logic [7:0] d;
        int hi_seen;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        check("R13 txd", 32'(txd), 32'd1);
        check("R13 rts_n", 32'(rts_n), 32'd0);
        check("R13 rx_empty", 32'(rx_empty), 32'd1);
        check("R13 tx_full", 32'(tx_full), 32'd0);
        check("R13 err_flags", 32'(err_flags), 32'd0);
        check("R13 irq", 32'(irq), 32'd0);

        // R1 bit period, including divisor 0 acting as 1
        bit_time_case(3);
        bit_time_case(0);

        // R4 fractional stop lengths at the corners and inside
        stop_case(0, 2);
        stop_case(15, 2);
        stop_case(31, 3);
        stop_case(7, 0);
        stop_case(int'($urandom % 32), 2);

        // R2 / R3 loopback with every length and parity mode
        loop_case(0, 1, 15, 2, 6);
        loop_case(1, 2, 20, 2, 6);
        loop_case(2, 0, 31, 2, 6);
        loop_case(3, 3, 12, 3, 6);
        for (int k = 0; k < 3; k++)
            loop_case(int'($urandom % 4), int'($urandom % 3), 11 + int'($urandom % 21), 2, 8);

        // R5 short low pulse is not a start bit
        wr(2'd0, 16'd2);
        wr(2'd1, fmt_word(3, 0, 15, 1'b0));
        @(negedge clk);
        drv_rxd = 1'b0;
        idle(5 * 2);
        drv_rxd = 1'b1;
        idle(16 * 2 * 12);
        check("R5 glitch gives no char", 32'(rx_empty), 32'd1);
        check("R5 glitch gives no error", 32'(err_flags), 32'd0);

        // R7 parity error, character kept; R12 masking
        wr(2'd1, fmt_word(3, 1, 15, 1'b0));
        drive_frame(8'h5A, 3, 1, 1'b1, 1'b1, 2);
        check("R7 parity flag", 32'(err_flags), 32'b001);
        check("R7 char stored", 32'(rx_data), 32'h5A);
        check("R12 masked sources keep irq low", 32'(irq), 32'd0);
        wr(2'd2, 16'b00100);
        check("R12 parity source raises irq", 32'(irq), 32'd1);
        wr(2'd2, 16'b00001);
        check("R12 rx available raises irq", 32'(irq), 32'd1);
        pop(d);
        check("R12 irq drops when rx empties", 32'(irq), 32'd0);
        // R11 clearing another bit leaves parity flag set
        wr(2'd3, 16'b010);
        check("R11 unrelated clear keeps flag", 32'(err_flags), 32'b001);
        wr(2'd3, 16'b001);
        check("R11 write-one clears flag", 32'(err_flags), 32'b000);

        // R6 framing error on low first stop sample; odd parity 7-bit
        wr(2'd1, fmt_word(2, 2, 15, 1'b0));
        drive_frame(8'h33, 2, 2, 1'b0, 1'b0, 2);
        check("R6 framing flag", 32'(err_flags), 32'b010);
        check("R6 char stored", 32'(rx_data), 32'h33);
        wr(2'd2, 16'b01000);
        check("R12 framing source raises irq", 32'(irq), 32'd1);
        pop(d);
        wr(2'd3, 16'b111);
        wr(2'd2, 16'b00000);

        // R9 flow request and R8 overrun
        wr(2'd1, fmt_word(3, 0, 15, 1'b0));
        for (int i = 0; i < 6; i++) drive_frame(8'(8'h10 + i), 3, 0, 1'b0, 1'b1, 2);
        check("R9 rts low with room", 32'(rts_n), 32'd0);
        drive_frame(8'h16, 3, 0, 1'b0, 1'b1, 2);
        check("R9 rts high at depth-1", 32'(rts_n), 32'd1);
        drive_frame(8'h17, 3, 0, 1'b0, 1'b1, 2);
        check("R8 no overrun when just full", 32'(err_flags), 32'd0);
        drive_frame(8'hEE, 3, 0, 1'b0, 1'b1, 2);
        check("R8 overrun flag", 32'(err_flags), 32'b100);
        for (int i = 0; i < 8; i++) begin
            pop(d);
            check("R8 kept contents in order", 32'(d), 32'(8'h10 + i));
        end
        check("R8 extra char discarded", 32'(rx_empty), 32'd1);
        check("R9 rts low after drain", 32'(rts_n), 32'd0);
        wr(2'd3, 16'b111);

        // R10 flow control holds off the start
        loop_en = 1'b1;
        cts_n = 1'b1;
        wr(2'd1, fmt_word(3, 0, 15, 1'b1));
        push(8'hA5);
        hi_seen = 0;
        for (int i = 0; i < 16 * 2 * 24; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) hi_seen++;
        end
        check("R10 no start while cts high", 32'(hi_seen), 32'd0);
        cts_n = 1'b0;
        idle(16 * 2 * 12);
        check("R10 sends after cts", 32'(rx_data), 32'hA5);
        pop(d);
        // character in flight completes, next one waits
        push(8'h3C);
        push(8'hC3);
        wait_txd(1'b0);
        idle(16 * 2 * 3);
        cts_n = 1'b1;
        idle(16 * 2 * 20);
        check("R10 in-flight char completes", 32'(rx_data), 32'h3C);
        pop(d);
        check("R10 next char held", 32'(rx_empty), 32'd1);
        cts_n = 1'b0;
        idle(16 * 2 * 12);
        check("R10 held char sent after release", 32'(rx_data), 32'hC3);
        pop(d);
        wr(2'd2, 16'b00010);
        check("R12 tx drained source", 32'(irq), 32'd1);
        loop_en = 1'b0;

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule